// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single-word host accesses into correctly timed bus cycles on an asynchronous NAND flash interface. The host presents an access on one of four ports (data, command, address, control). A command access becomes a latch cycle with the command-latch line raised, an address access the same cycle with the address-latch line raised, and a data access a read or write strobe cycle. Every strobe cycle has three phases: setup (latch lines settled, strobe idle), active (strobe low) and hold (strobe released, lines still held). The length of each phase comes from a separately programmed field.

The control port holds the three timing fields, a chip-disable bit that drives the active-low chip enable, and a one-shot request that clears an external ECC accumulator. Reading the control port also returns the flash ready/busy state after a two-flop synchronizer. In the extended variant a data access may be a 32-bit word that is carried as four back-to-back byte cycles. While a bus cycle runs, the host port holds its ready low and any new access waits.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset the host port is ready, chip enable is high (deselected), both strobes are high, both latch lines are low, and the control image reads setup field 7 (extended variant; 3 in the base variant), active field 7 and hold field 7, chip-disable 1.
- R2: Each timing field holds the wanted clock count minus one: a byte cycle spends setup+1 clocks with the strobe high, then active+1 clocks with the strobe low, then hold+1 clocks with the strobe high. The setup field is 3 bits wide in the extended variant and 2 bits in the base variant; active and hold are 3 bits.
- R3: A command-port access issues a write-strobe cycle with the command-latch line high for the whole cycle, the address-latch line low, and the low byte of the host data driven on the data bus. The host write flag is not used for this port.
- R4: An address-port access issues the same cycle shape with the address-latch line high and the command-latch line low.
- R5: A data-port read (host write flag 0) issues read-strobe cycles with both latch lines low and the data bus not driven; the flash byte is sampled on the last clock of the active phase and returned on host_rdata bits 7:0 (upper bits zero) with a one-clock host_rvalid pulse in the cycle the port becomes ready again.
- R6: A data-port write (host write flag 1) issues write-strobe cycles with both latch lines low and the data bus driven; no host_rvalid follows.
- R7: In the extended variant a data access with host_wide set runs four byte cycles, each with all three phases, lane 0 (bits 7:0) first; a wide read returns lane i of the word from the i-th byte cycle.
- R8: host_ready is low from the clock after an accepted bus access until the last hold phase ends, exactly bytes x (setup+active+hold+3) clocks; an access held on the port meanwhile is accepted only after that.
- R9: Control register bit 12 drives chip enable directly: 1 leaves nand_ce_n high, 0 drives it low, from the clock after the write.
- R10: Control read bit 16 is the flash ready/busy input (1 = ready) after two synchronizer flops; a change is not visible in a read accepted one clock after it.
- R11: Writing control bit 13 as 1 raises ecc_clr for exactly one clock after the write; the bit reads back as 0.
- R12: The read and write strobes are never low together and the two latch lines are never high together.

Control register image: bits 2:0 setup, 6:4 active, 10:8 hold, 12 chip-disable, 13 ECC clear (write only), 16 ready status (read only); a control read returns it with host_rvalid on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Port free; access taken when valid and ready |
| host_sel | input | 2 | 0 data, 1 command, 2 address, 3 control |
| host_we | input | 1 | 1 write, 0 read |
| host_wide | input | 1 | 32-bit data access (extended variant) |
| host_wdata | input | 32 | Write data |
| host_rvalid | output | 1 | Read data valid pulse |
| host_rdata | output | 32 | Read data |
| ecc_clr | output | 1 | One-clock ECC accumulator clear |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_in | input | 8 | Data bus in |
| nand_rb | input | 1 | Flash ready/busy, asynchronous, 1 = ready |

## Verification
A wrong phase counter or phase register shows up within the same byte cycle as a strobe edge one or more clocks away from the position set by the fields, or as a ready interval of the wrong length. A wrong byte index shows as the wrong data lane on the bus during the next strobe, or as a misplaced lane in the word returned at the end of a wide read. Faults in the control storage show on the very next control read or, for the chip-enable and clear bits, on the pins one clock after the write.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  localparam logic [1:0] PORT_DATA = 2'd0;
  localparam logic [1:0] PORT_CMD  = 2'd1;
  localparam logic [1:0] PORT_ADDR = 2'd2;
  localparam logic [1:0] PORT_CTRL = 2'd3;

  localparam int TIME_W  = 3;
  localparam int LANES   = 4;

  // pick one byte lane out of a word
  function automatic logic [7:0] lane_of(input logic [31:0] w, input logic [1:0] idx);
    return w[{idx, 3'b000} +: 8];
  endfunction

  // control read image
  function automatic logic [31:0] ctrl_image(input logic [2:0] s, input logic [2:0] a,
                                             input logic [2:0] h, input logic ce_off,
                                             input logic rdy);
    return {15'd0, rdy, 3'd0, ce_off, 1'b0, h, 1'b0, a, 1'b0, s};
  endfunction

  // clocks in one byte cycle for the given fields
  function automatic int byte_clocks(input logic [2:0] s, input logic [2:0] a,
                                     input logic [2:0] h);
    return int'(s) + int'(a) + int'(h) + 3;
  endfunction

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/nand_cfg_regs.sv
module nand_cfg_regs #(
  parameter int EXT_VARIANT = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] setup_in,
  input  logic [2:0] act_in,
  input  logic [2:0] hold_in,
  input  logic       ce_off_in,
  input  logic       ecc_req_in,
  output logic [2:0] setup_m1,
  output logic [2:0] act_m1,
  output logic [2:0] hold_m1,
  output logic       ce_off,
  output logic       ecc_clr
);
  localparam int SETUP_W = (EXT_VARIANT != 0) ? 3 : 2;

  logic [SETUP_W-1:0] setup_q;
  logic [2:0]         act_q;
  logic [2:0]         hold_q;
  logic               ce_off_q;
  logic               ecc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q  <= '1;
      act_q    <= '1;
      hold_q   <= '1;
      ce_off_q <= 1'b1;
      ecc_q    <= 1'b0;
    end else begin
      ecc_q <= wr_en && ecc_req_in;
      if (wr_en) begin
        setup_q  <= setup_in[SETUP_W-1:0];
        act_q    <= act_in;
        hold_q   <= hold_in;
        ce_off_q <= ce_off_in;
      end
    end
  end

  generate
    if (SETUP_W == 3) begin : g_setup_wide
      assign setup_m1 = setup_q;
    end else begin : g_setup_narrow
      assign setup_m1 = {1'b0, setup_q};
    end
  endgenerate

  assign act_m1  = act_q;
  assign hold_m1 = hold_q;
  assign ce_off  = ce_off_q;
  assign ecc_clr = ecc_q;
endmodule

// File: rtl/nand_cycle_fsm.sv
module nand_cycle_fsm
  import nand_seq_pkg::*;
#(
  parameter int EXT_VARIANT = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  start_kind,
  input  logic        start_read,
  input  logic        start_wide,
  input  logic [31:0] start_wdata,
  input  logic [2:0]  setup_m1,
  input  logic [2:0]  act_m1,
  input  logic [2:0]  hold_m1,
  input  logic [7:0]  dq_in,
  output phase_e      phase,
  output logic [1:0]  kind,
  output logic        is_read,
  output logic [7:0]  cur_byte,
  output logic [31:0] rd_word,
  output logic        finish
);
  localparam bit WIDE_OK = (EXT_VARIANT != 0);
  localparam int IDX_W   = $clog2(LANES);

  phase_e             phase_q;
  logic [TIME_W-1:0]  cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   last_q;
  logic [1:0]         kind_q;
  logic               read_q;
  logic [31:0]        wbuf_q;
  logic [31:0]        rbuf_q;

  logic step_done;
  logic go_wide;

  assign step_done = (cnt_q == '0);
  assign go_wide   = WIDE_OK && start_wide && (start_kind == PORT_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      kind_q  <= PORT_DATA;
      read_q  <= 1'b0;
      wbuf_q  <= '0;
      rbuf_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_SETUP;
            cnt_q   <= setup_m1;
            idx_q   <= '0;
            last_q  <= go_wide ? IDX_W'(LANES - 1) : '0;
            kind_q  <= start_kind;
            read_q  <= start_read && (start_kind == PORT_DATA);
            wbuf_q  <= start_wdata;
            rbuf_q  <= '0;
          end
        end
        PH_SETUP: begin
          if (step_done) begin
            phase_q <= PH_ACTIVE;
            cnt_q   <= act_m1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_ACTIVE: begin
          if (step_done) begin
            phase_q <= PH_HOLD;
            cnt_q   <= hold_m1;
            if (read_q) rbuf_q[{idx_q, 3'b000} +: 8] <= dq_in;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HOLD: begin
          if (step_done) begin
            if (idx_q == last_q) begin
              phase_q <= PH_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              phase_q <= PH_SETUP;
              cnt_q   <= setup_m1;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase    = phase_q;
  assign kind     = kind_q;
  assign is_read  = read_q;
  assign cur_byte = lane_of(wbuf_q, idx_q);
  assign rd_word  = rbuf_q;
  assign finish   = (phase_q == PH_HOLD) && step_done && (idx_q == last_q);
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int EXT_VARIANT = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_valid,
  output logic        host_ready,
  input  logic [1:0]  host_sel,
  input  logic        host_we,
  input  logic        host_wide,
  input  logic [31:0] host_wdata,
  output logic        host_rvalid,
  output logic [31:0] host_rdata,
  output logic        ecc_clr,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_out,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_in,
  input  logic        nand_rb
);
  // named internal events
  logic        accept;
  logic        ctrl_acc;
  logic        cyc_start;
  logic        rb_status;
  logic [2:0]  cfg_setup;
  logic [2:0]  cfg_act;
  logic [2:0]  cfg_hold;
  logic        cfg_ce_off;
  phase_e      phase;
  logic [1:0]  kind;
  logic        is_read;
  logic [7:0]  cur_byte;
  logic [31:0] rd_word;
  logic        finish;
  logic        strobe_on;
  logic        in_cycle;
  logic        rvalid_q;
  logic [31:0] rdata_q;

  assign host_ready = (phase == PH_IDLE);
  assign accept     = host_valid && host_ready;
  assign ctrl_acc   = accept && (host_sel == PORT_CTRL);
  assign cyc_start  = accept && (host_sel != PORT_CTRL);

  nand_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (nand_rb),
    .sync_out (rb_status)
  );

  nand_cfg_regs #(.EXT_VARIANT(EXT_VARIANT)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ctrl_acc && host_we),
    .setup_in   (host_wdata[2:0]),
    .act_in     (host_wdata[6:4]),
    .hold_in    (host_wdata[10:8]),
    .ce_off_in  (host_wdata[12]),
    .ecc_req_in (host_wdata[13]),
    .setup_m1   (cfg_setup),
    .act_m1     (cfg_act),
    .hold_m1    (cfg_hold),
    .ce_off     (cfg_ce_off),
    .ecc_clr    (ecc_clr)
  );

  nand_cycle_fsm #(.EXT_VARIANT(EXT_VARIANT)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (cyc_start),
    .start_kind  (host_sel),
    .start_read  (!host_we),
    .start_wide  (host_wide),
    .start_wdata (host_wdata),
    .setup_m1    (cfg_setup),
    .act_m1      (cfg_act),
    .hold_m1     (cfg_hold),
    .dq_in       (nand_dq_in),
    .phase       (phase),
    .kind        (kind),
    .is_read     (is_read),
    .cur_byte    (cur_byte),
    .rd_word     (rd_word),
    .finish      (finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= (ctrl_acc && !host_we) || (finish && is_read);
      if (ctrl_acc && !host_we)
        rdata_q <= ctrl_image(cfg_setup, cfg_act, cfg_hold, cfg_ce_off, rb_status);
      else if (finish && is_read)
        rdata_q <= rd_word;
    end
  end

  assign host_rvalid = rvalid_q;
  assign host_rdata  = rdata_q;

  assign in_cycle    = (phase != PH_IDLE);
  assign strobe_on   = (phase == PH_ACTIVE);
  assign nand_ce_n   = cfg_ce_off;
  assign nand_cle    = in_cycle && (kind == PORT_CMD);
  assign nand_ale    = in_cycle && (kind == PORT_ADDR);
  assign nand_we_n   = !(strobe_on && !is_read);
  assign nand_re_n   = !(strobe_on && is_read);
  assign nand_dq_oe  = in_cycle && !is_read;
  assign nand_dq_out = cur_byte;
endmodule

// File: rtl/nand_cycle_seq_chk.sv
module nand_cycle_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_ready,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_dq_oe,
  input logic       ecc_clr,
  input logic       nand_rb,
  input logic       rb_status,
  input logic [2:0] cfg_act
);
  logic       strobe_low;
  logic [3:0] low_run;
  logic [1:0] since_rst;

  assign strobe_low = !nand_we_n || !nand_re_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run   <= '0;
      since_rst <= '0;
    end else begin
      low_run <= strobe_low ? low_run + 1'b1 : 4'd0;
      if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
    end
  end

  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  p_latch_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  p_busy_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_low || nand_cle || nand_ale || nand_dq_oe) |-> !host_ready);

  p_strobe_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_low && $past(strobe_low)) |-> (low_run == {1'b0, cfg_act} + 4'd1));

  p_ecc_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_clr |=> !ecc_clr);

  p_rb_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (rb_status == $past(nand_rb, 2)));
endmodule

bind nand_cycle_seq nand_cycle_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_ready (host_ready),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_cle   (nand_cle),
  .nand_ale   (nand_ale),
  .nand_dq_oe (nand_dq_oe),
  .ecc_clr    (ecc_clr),
  .nand_rb    (nand_rb),
  .rb_status  (rb_status),
  .cfg_act    (cfg_act)
);

// File: tb/nand_cycle_seq_tb.sv
`timescale 1ns/1ps
module nand_cycle_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_valid;
  logic        host_ready;
  logic [1:0]  host_sel;
  logic        host_we;
  logic        host_wide;
  logic [31:0] host_wdata;
  logic        host_rvalid;
  logic [31:0] host_rdata;
  logic        ecc_clr;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in;
  logic        nand_rb;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int tag    = 0;

  logic [2:0] es, ea, eh;
  logic       ece;

  always #4 clk = ~clk;

  nand_cycle_seq u_dut (.*);

  function automatic logic [7:0] rd_model(input int bi, input int tg);
    return 8'((tg * 37) + (bi * 91) + 5);
  endfunction

  function automatic logic [31:0] cfg_word(input logic [2:0] s, input logic [2:0] a,
                                           input logic [2:0] h, input logic ce, input logic ecc);
    return (32'(s)) | (32'(a) << 4) | (32'(h) << 8) | (32'(ce) << 12) | (32'(ecc) << 13);
  endfunction

  function automatic logic [31:0] exp_image(input logic rdy);
    return (32'(es)) | (32'(ea) << 4) | (32'(eh) << 8) | (32'(ece) << 12) | (32'(rdy) << 16);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic ctrl_wr(input logic [31:0] w);
    @(negedge clk);
    host_valid = 1; host_sel = 2'd3; host_we = 1; host_wide = 0; host_wdata = w;
    @(posedge clk);
    @(negedge clk);
    host_valid = 0;
    es = w[2:0]; ea = w[6:4]; eh = w[10:8]; ece = w[12];
  endtask

  task automatic ctrl_rd(output logic [31:0] d);
    @(negedge clk);
    host_valid = 1; host_sel = 2'd3; host_we = 0; host_wide = 0;
    @(posedge clk);
    @(negedge clk);
    host_valid = 0;
    check(host_rvalid == 1'b1, "R1", "control read rvalid", 32'(host_rvalid), 32'd1);
    d = host_rdata;
  endtask

  task automatic run_cycle(input logic [1:0] sel, input bit rd, input bit wide,
                           input logic [31:0] wd);
    int nbytes, per, t, pos, bi;
    bit eff_rd, bad_str, bad_lat, bad_dq, bad_excl, exp_low, act_low, oth_low;
    logic [31:0] exp_word;
    string lreq;
    tag++;
    eff_rd = rd && (sel == 2'd0);
    nbytes = (wide && sel == 2'd0) ? 4 : 1;
    per    = int'(es) + int'(ea) + int'(eh) + 3;
    exp_word = '0;
    for (int k = 0; k < nbytes; k++) exp_word[k*8 +: 8] = rd_model(k, tag);
    lreq = (sel == 2'd1) ? "R3" : (sel == 2'd2) ? "R4" : (eff_rd ? "R5" : "R6");
    bad_str = 0; bad_lat = 0; bad_dq = 0; bad_excl = 0;
    @(negedge clk);
    host_valid = 1; host_sel = sel; host_we = !rd; host_wide = wide; host_wdata = wd;
    nand_dq_in = rd_model(0, tag);
    @(posedge clk);
    @(negedge clk);
    host_valid = 0;
    t = 1;
    while (!host_ready && t < 200) begin
      pos = (t - 1) % per;
      bi  = (t - 1) / per;
      nand_dq_in = rd_model(bi, tag);
      exp_low = (pos >= int'(es) + 1) && (pos <= int'(es) + int'(ea) + 1);
      act_low = eff_rd ? !nand_re_n : !nand_we_n;
      oth_low = eff_rd ? !nand_we_n : !nand_re_n;
      if (act_low != exp_low || oth_low) bad_str = 1;
      if (nand_cle != (sel == 2'd1) || nand_ale != (sel == 2'd2)) bad_lat = 1;
      if (nand_dq_oe != !eff_rd) bad_dq = 1;
      if (!eff_rd && bi < 4 && nand_dq_out != wd[bi*8 +: 8]) bad_dq = 1;
      if ((!nand_we_n && !nand_re_n) || (nand_cle && nand_ale)) bad_excl = 1;
      t++;
      @(negedge clk);
    end
    check(!bad_str, "R2", "strobe phase positions", 32'(bad_str), 32'd0);
    check(!bad_lat, lreq, "latch lines during cycle", 32'(bad_lat), 32'd0);
    check(!bad_dq, lreq, "data bus drive and lane", 32'(bad_dq), 32'd0);
    check(!bad_excl, "R12", "strobe/latch exclusion", 32'(bad_excl), 32'd0);
    check(t - 1 == nbytes * per, (nbytes == 4) ? "R7" : "R8", "busy clocks",
          32'(t - 1), 32'(nbytes * per));
    if (eff_rd) begin
      check(host_rvalid == 1'b1, "R5", "read rvalid at completion", 32'(host_rvalid), 32'd1);
      check(host_rdata == exp_word, (nbytes == 4) ? "R7" : "R5", "read data",
            host_rdata, exp_word);
    end else begin
      check(host_rvalid == 1'b0, "R6", "no rvalid after write", 32'(host_rvalid), 32'd0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] r;
    bit bad;
    void'($urandom(32'h5eed));
    rst_n = 0; host_valid = 0; host_sel = 0; host_we = 0; host_wide = 0;
    host_wdata = 0; nand_dq_in = 0; nand_rb = 1;
    es = 3'd7; ea = 3'd7; eh = 3'd7; ece = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(host_ready == 1, "R1", "ready after reset", 32'(host_ready), 32'd1);
    check(nand_ce_n == 1, "R1", "ce_n after reset", 32'(nand_ce_n), 32'd1);
    check(nand_we_n && nand_re_n && !nand_cle && !nand_ale, "R1", "pins idle after reset",
          {28'd0, nand_we_n, nand_re_n, nand_cle, nand_ale}, 32'hc);
    repeat (3) @(negedge clk);
    ctrl_rd(d);
    check(d == 32'h0001_1777, "R1", "control image after reset", d, 32'h0001_1777);

    // default timing command cycle
    run_cycle(2'd1, 0, 0, 32'h0000_0090);

    // R9 chip enable
    ctrl_wr(cfg_word(3'd1, 3'd2, 3'd0, 1'b0, 1'b0));
    check(nand_ce_n == 0, "R9", "ce_n after clearing bit", 32'(nand_ce_n), 32'd0);
    ctrl_wr(cfg_word(3'd1, 3'd2, 3'd0, 1'b1, 1'b0));
    check(nand_ce_n == 1, "R9", "ce_n after setting bit", 32'(nand_ce_n), 32'd1);
    ctrl_wr(cfg_word(3'd0, 3'd0, 3'd0, 1'b0, 1'b0));

    // R2 minimal timing, R4 address, R5/R6 data, R7 word
    run_cycle(2'd2, 0, 0, 32'h0000_0012);
    run_cycle(2'd0, 1, 0, 32'h0);
    run_cycle(2'd0, 0, 0, 32'h0000_00a5);
    run_cycle(2'd0, 1, 1, 32'h0);
    run_cycle(2'd0, 0, 1, 32'hdead_beef);
    run_cycle(2'd1, 1, 1, 32'h0000_0070);

    // R11 ECC clear one-shot
    ctrl_wr(cfg_word(3'd2, 3'd1, 3'd3, 1'b0, 1'b1));
    check(ecc_clr == 1, "R11", "ecc_clr pulse", 32'(ecc_clr), 32'd1);
    @(negedge clk);
    check(ecc_clr == 0, "R11", "ecc_clr one clock only", 32'(ecc_clr), 32'd0);
    ctrl_rd(d);
    r = exp_image(1'b1);
    check(d == r, "R11", "ecc bit reads zero", d, r);

    // R10 ready/busy synchronizer latency
    nand_rb = 0;
    repeat (3) @(negedge clk);
    ctrl_rd(d);
    check(d[16] == 0, "R10", "status busy", 32'(d[16]), 32'd0);
    nand_rb = 1;
    ctrl_rd(d);
    check(d[16] == 0, "R10", "status not yet ready after one clock", 32'(d[16]), 32'd0);
    repeat (2) @(negedge clk);
    ctrl_rd(d);
    check(d[16] == 1, "R10", "status ready after sync", 32'(d[16]), 32'd1);

    // R8 access held during a cycle waits
    @(negedge clk);
    host_valid = 1; host_sel = 2'd1; host_we = 1; host_wide = 0; host_wdata = 32'h60;
    @(posedge clk);
    @(negedge clk);
    host_sel = 2'd3; host_we = 1; host_wdata = cfg_word(es, ea, eh, ece, 1'b1);
    bad = 0;
    while (!host_ready) begin
      if (ecc_clr) bad = 1;
      @(negedge clk);
    end
    check(!bad, "R8", "held access not taken while busy", 32'(bad), 32'd0);
    @(posedge clk);
    @(negedge clk);
    host_valid = 0;
    check(ecc_clr == 1, "R8", "held access taken after cycle", 32'(ecc_clr), 32'd1);

    // random mix
    for (int i = 0; i < 30; i++) begin
      logic [31:0] w;
      int pick;
      w = $urandom;
      ctrl_wr(cfg_word(w[2:0], w[6:4], w[10:8], 1'b0, 1'b0));
      pick = $urandom % 4;
      case (pick)
        0: run_cycle(2'd1, 0, 0, $urandom);
        1: run_cycle(2'd2, 0, 0, $urandom);
        2: run_cycle(2'd0, w[16], 0, $urandom);
        default: run_cycle(2'd0, w[17], 1, $urandom);
      endcase
      if (w[20]) begin
        ctrl_rd(d);
        r = exp_image(1'b1);
        check(d == r, "R2", "control image readback", d, r);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule